// File: doc/BRIEF.md
# Disk Controller Lockable Configuration Registers

This block holds the recording mode and configuration state of a floppy disk controller. The command parser upstream hands it decoded command strobes together with their data bytes. It keeps three groups of state. The first is the FIFO setup from a configure command: FIFO disable, FIFO threshold and precompensation start track. The second is the perpendicular recording controls: the write-gate bit, the gap bit and one perpendicular bit per drive. The third is a lock flag, which shields the FIFO setup from software resets.

Two reset classes reach different parts of this state. The active-low hardware reset pin returns everything to defaults. A software reset can come from the digital-output register reset bit or from the data-rate register reset bit. It always clears the gap and write-gate bits. It restores the FIFO setup only while the lock flag is clear, and it never touches the per-drive bits or the lock flag.

A small result state machine returns one result byte for a lock command and one snapshot byte for a dump command. It has three states: `RS_IDLE`, `RS_LOCK` and `RS_DUMP`.
- From any state, a software reset moves it to `RS_IDLE`.
- Otherwise, a lock strobe moves it to `RS_LOCK`.
- Otherwise, a dump strobe moves it to `RS_DUMP`.
- With none of these, it returns to `RS_IDLE`.

A combinational decoder turns the current {write-gate, gap} pair into a recording mode, a gap-2 length and the number of gap-2 bytes rewritten on a data write.

Top module: `fdc_cfg_regs`

## Requirements
- R1: While `rst_n` is low, the outputs take their default values: `efifo`=1, `fifo_thr`=0, `pretrk`=0, `lock`=0, `wgate`=0, `gap`=0, `drv_perp`=0 and `res_valid`=0. In this state `perp_mode`=0, `gap2_len`=22 and `gap2_rewr`=0. The same values apply whatever `lock` was before the reset.
- R2: A software reset is `dor_srst` or `dsr_srst` high at a clock edge. At that edge it clears `wgate` and `gap` to 0 and leaves `drv_perp` unchanged.
- R3: A software reset while `lock`=1 leaves `efifo`, `fifo_thr` and `pretrk` at their programmed values.
- R4: A software reset while `lock`=0 sets `efifo`=1, `fifo_thr`=0 and `pretrk`=0.
- R5: `cfg_wr` high at an edge loads `cfg_efifo`, `cfg_thr` and `cfg_trk` into `efifo`, `fifo_thr` and `pretrk` at that edge.
- R6: `perp_wr` high at an edge loads `perp_cmd[0]` into `wgate` and `perp_cmd[1]` into `gap`. It loads `perp_cmd[5:2]` into `drv_perp[3:0]` only when `perp_cmd[7]`=1; otherwise `drv_perp` is kept.
- R7: `lock_wr` high at an edge loads `lock_cmd[7]` into `lock`. In the following cycle `res_valid`=1 and `res_byte` carries the new lock value in bit 4, with every other bit 0.
- R8: `dump_req` high at an edge, with no `lock_wr`, gives `res_valid`=1 in the following cycle. `res_byte` is then {lock, 0, drv_perp[3:0], gap, wgate}, taken from the values present before that edge.
- R9: `perp_mode`, `gap2_len` and `gap2_rewr` follow {wgate, gap}:

  | {wgate, gap} | `perp_mode` | `gap2_len` | `gap2_rewr` | Meaning |
  |---|---|---|---|---|
  | 00 | 0 | 22 | 0 | conventional |
  | 10 | 1 | 22 | 19 | perpendicular, 500 kbps |
  | 01 | 2 | 22 | 0 | reserved, behaves as conventional |
  | 11 | 3 | 41 | 38 | perpendicular, 1 Mbps |
- R10: A software reset in the same cycle as a command strobe takes priority. No configure, perpendicular or lock write takes effect, and no result is produced in the next cycle.
- R11: When `lock_wr` and `dump_req` are high together, the lock result is returned. `res_valid` lasts one cycle per command. While `res_valid`=0, `res_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| dor_srst | input | 1 | Software reset from the digital-output register |
| dsr_srst | input | 1 | Software reset from the data-rate register |
| cfg_wr | input | 1 | Configure command strobe |
| cfg_efifo | input | 1 | New FIFO disable value (1 = FIFO off) |
| cfg_thr | input | 4 | New FIFO threshold |
| cfg_trk | input | 8 | New precompensation start track |
| perp_wr | input | 1 | Perpendicular command strobe |
| perp_cmd | input | 8 | Perpendicular data byte (bit 7 drive-bit enable, 5:2 drives, 1 gap, 0 write gate) |
| lock_wr | input | 1 | Lock command strobe |
| lock_cmd | input | 8 | Lock command byte (bit 7 = new lock value) |
| dump_req | input | 1 | Dump command strobe |
| efifo | output | 1 | FIFO disable |
| fifo_thr | output | 4 | FIFO threshold |
| pretrk | output | 8 | Precompensation start track |
| lock | output | 1 | Lock flag |
| wgate | output | 1 | Write-gate perpendicular control |
| gap | output | 1 | Gap perpendicular control |
| drv_perp | output | 4 | Per-drive perpendicular bits |
| perp_mode | output | 2 | Recording mode code |
| gap2_len | output | 6 | Gap-2 length in bytes |
| gap2_rewr | output | 6 | Gap-2 bytes rewritten on data write |
| res_valid | output | 1 | Result byte valid |
| res_byte | output | 8 | Result byte |

## Verification
The bench compares every output against a behavioural reference model on every clock. It targets these corner cases:
- A software reset with the lock flag set. A design that restores defaults anyway would lose the programmed FIFO threshold and track.
- A software reset with the lock flag clear. A design that also cleared the per-drive bits would drop each drive to conventional mode.
- A software reset in the same cycle as lock and configure strobes. A design that let the command win would change state and emit a stray result.
- A lock strobe and a dump strobe in the same cycle, which checks that the lock result wins.
- A perpendicular write with the drive-bit enable clear, which must keep the per-drive bits.
- The reserved mode code, which must decode as conventional.
- A hardware reset after locking, which must clear everything.

// File: rtl/fdc_cfg_pkg.sv
package fdc_cfg_pkg;
    localparam int NUM_DRV = 4;
    localparam int LEN_W   = 6;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_LOCK = 2'd1,
        RS_DUMP = 2'd2
    } res_state_e;

    typedef enum logic [1:0] {
        REC_CONV = 2'd0,
        REC_P500 = 2'd1,
        REC_RSVD = 2'd2,
        REC_P1M  = 2'd3
    } rec_mode_e;

    localparam logic [LEN_W-1:0] GAP2_SHORT = LEN_W'(22);
    localparam logic [LEN_W-1:0] GAP2_LONG  = LEN_W'(41);
    localparam logic [LEN_W-1:0] REWR_NONE  = LEN_W'(0);
    localparam logic [LEN_W-1:0] REWR_P500  = LEN_W'(19);
    localparam logic [LEN_W-1:0] REWR_P1M   = LEN_W'(38);
endpackage

// File: rtl/fdc_fifo_cfg.sv
module fdc_fifo_cfg #(
    parameter int THR_W = 4,
    parameter int TRK_W = 8,
    parameter logic DEF_EFIFO = 1'b1,
    parameter int DEF_THR = 0,
    parameter int DEF_TRK = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swr,
    input  logic             cfg_wr,
    input  logic             cfg_efifo,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic [TRK_W-1:0] cfg_trk,
    input  logic             lock_wr,
    input  logic             lock_new,
    output logic             efifo,
    output logic [THR_W-1:0] fifo_thr,
    output logic [TRK_W-1:0] pretrk,
    output logic             lock
);
    localparam logic [THR_W-1:0] THR_RST = THR_W'(DEF_THR);
    localparam logic [TRK_W-1:0] TRK_RST = TRK_W'(DEF_TRK);

    // Configuration fields: shielded from software reset while locked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            efifo    <= DEF_EFIFO;
            fifo_thr <= THR_RST;
            pretrk   <= TRK_RST;
        end else if (swr) begin
            if (!lock) begin
                efifo    <= DEF_EFIFO;
                fifo_thr <= THR_RST;
                pretrk   <= TRK_RST;
            end
        end else if (cfg_wr) begin
            efifo    <= cfg_efifo;
            fifo_thr <= cfg_thr;
            pretrk   <= cfg_trk;
        end
    end

    // Lock flag: only the hardware reset clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock <= 1'b0;
        end else if (!swr && lock_wr) begin
            lock <= lock_new;
        end
    end

    p_lock_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (swr && lock) |=> ($stable(efifo) && $stable(fifo_thr) && $stable(pretrk)));

    p_unlock_dflt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swr && !lock) |=> (efifo == DEF_EFIFO && fifo_thr == THR_RST && pretrk == TRK_RST));

    p_swr_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> $stable(lock));
endmodule

// File: rtl/fdc_perp_ctl.sv
module fdc_perp_ctl
    import fdc_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swr,
    input  logic               perp_wr,
    input  logic               drv_we,
    input  logic [NUM_DRV-1:0] drv_in,
    input  logic               gap_in,
    input  logic               wg_in,
    output logic               wgate,
    output logic               gap,
    output logic [NUM_DRV-1:0] drv_perp
);
    // Mode bits: cleared by either reset class.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wgate <= 1'b0;
            gap   <= 1'b0;
        end else if (swr) begin
            wgate <= 1'b0;
            gap   <= 1'b0;
        end else if (perp_wr) begin
            wgate <= wg_in;
            gap   <= gap_in;
        end
    end

    // One perpendicular bit per drive: only the hardware reset clears them.
    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drv_perp[d] <= 1'b0;
            end else if (!swr && perp_wr && drv_we) begin
                drv_perp[d] <= drv_in[d];
            end
        end
    end

    p_swr_clr_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (!wgate && !gap));

    p_swr_keep_drv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> $stable(drv_perp));

    p_drv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (perp_wr && !drv_we) |=> $stable(drv_perp));
endmodule

// File: rtl/fdc_gap_decode.sv
module fdc_gap_decode
    import fdc_cfg_pkg::*;
(
    input  logic             wgate,
    input  logic             gap,
    output logic [1:0]       perp_mode,
    output logic [LEN_W-1:0] gap2_len,
    output logic [LEN_W-1:0] gap2_rewr
);
    rec_mode_e mode;

    always_comb begin
        unique case ({wgate, gap})
            2'b00: mode = REC_CONV;
            2'b10: mode = REC_P500;
            2'b01: mode = REC_RSVD;
            default: mode = REC_P1M;
        endcase
    end

    always_comb begin
        unique case (mode)
            REC_P500: begin
                gap2_len  = GAP2_SHORT;
                gap2_rewr = REWR_P500;
            end
            REC_P1M: begin
                gap2_len  = GAP2_LONG;
                gap2_rewr = REWR_P1M;
            end
            default: begin
                gap2_len  = GAP2_SHORT;
                gap2_rewr = REWR_NONE;
            end
        endcase
        perp_mode = mode;
    end

    always_comb begin
        p_rewr_fits_r9: assert (gap2_rewr < gap2_len);
    end
endmodule

// File: rtl/fdc_result_fsm.sv
module fdc_result_fsm
    import fdc_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       swr,
    input  logic       lock_wr,
    input  logic       lock_new,
    input  logic       dump_req,
    input  logic [7:0] dump_snap,
    output logic       res_valid,
    output logic [7:0] res_byte
);
    res_state_e state, state_nx;
    logic       cap_lock;
    logic [7:0] cap_dump;

    always_comb begin
        if (swr) begin
            state_nx = RS_IDLE;
        end else if (lock_wr) begin
            state_nx = RS_LOCK;
        end else if (dump_req) begin
            state_nx = RS_DUMP;
        end else begin
            state_nx = RS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_lock <= 1'b0;
            cap_dump <= 8'h00;
        end else begin
            if (state_nx == RS_LOCK) cap_lock <= lock_new;
            if (state_nx == RS_DUMP) cap_dump <= dump_snap;
        end
    end

    always_comb begin
        unique case (state)
            RS_LOCK: begin
                res_valid = 1'b1;
                res_byte  = {3'b000, cap_lock, 4'b0000};
            end
            RS_DUMP: begin
                res_valid = 1'b1;
                res_byte  = cap_dump;
            end
            default: begin
                res_valid = 1'b0;
                res_byte  = 8'h00;
            end
        endcase
    end

    p_lock_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && !swr) |=> (res_valid && res_byte == {3'b000, $past(lock_new), 4'b0000}));

    p_dump_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_req && !lock_wr && !swr) |=> (res_valid && res_byte == $past(dump_snap)));

    p_swr_nores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> !res_valid);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_byte == 8'h00));
endmodule

// File: rtl/fdc_cfg_regs.sv
module fdc_cfg_regs
    import fdc_cfg_pkg::*;
#(
    parameter int THR_W = 4,
    parameter int TRK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dor_srst,
    input  logic             dsr_srst,
    input  logic             cfg_wr,
    input  logic             cfg_efifo,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic [TRK_W-1:0] cfg_trk,
    input  logic             perp_wr,
    input  logic [7:0]       perp_cmd,
    input  logic             lock_wr,
    input  logic [7:0]       lock_cmd,
    input  logic             dump_req,
    output logic             efifo,
    output logic [THR_W-1:0] fifo_thr,
    output logic [TRK_W-1:0] pretrk,
    output logic             lock,
    output logic             wgate,
    output logic             gap,
    output logic [3:0]       drv_perp,
    output logic [1:0]       perp_mode,
    output logic [5:0]       gap2_len,
    output logic [5:0]       gap2_rewr,
    output logic             res_valid,
    output logic [7:0]       res_byte
);
    localparam int DRV_LSB = 2;

    logic       swr;
    logic [7:0] dump_snap;

    assign swr       = dor_srst | dsr_srst;
    assign dump_snap = {lock, 1'b0, drv_perp, gap, wgate};

    fdc_fifo_cfg #(
        .THR_W(THR_W), .TRK_W(TRK_W),
        .DEF_EFIFO(1'b1), .DEF_THR(0), .DEF_TRK(0)
    ) u_fifo_cfg (
        .clk(clk), .rst_n(rst_n), .swr(swr),
        .cfg_wr(cfg_wr), .cfg_efifo(cfg_efifo), .cfg_thr(cfg_thr), .cfg_trk(cfg_trk),
        .lock_wr(lock_wr), .lock_new(lock_cmd[7]),
        .efifo(efifo), .fifo_thr(fifo_thr), .pretrk(pretrk), .lock(lock)
    );

    fdc_perp_ctl u_perp (
        .clk(clk), .rst_n(rst_n), .swr(swr),
        .perp_wr(perp_wr), .drv_we(perp_cmd[7]),
        .drv_in(perp_cmd[DRV_LSB +: NUM_DRV]),
        .gap_in(perp_cmd[1]), .wg_in(perp_cmd[0]),
        .wgate(wgate), .gap(gap), .drv_perp(drv_perp)
    );

    fdc_gap_decode u_gdec (
        .wgate(wgate), .gap(gap),
        .perp_mode(perp_mode), .gap2_len(gap2_len), .gap2_rewr(gap2_rewr)
    );

    fdc_result_fsm u_res (
        .clk(clk), .rst_n(rst_n), .swr(swr),
        .lock_wr(lock_wr), .lock_new(lock_cmd[7]),
        .dump_req(dump_req), .dump_snap(dump_snap),
        .res_valid(res_valid), .res_byte(res_byte)
    );

    p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !swr) |=> (efifo == $past(cfg_efifo) && fifo_thr == $past(cfg_thr)
                              && pretrk == $past(cfg_trk)));

    p_swr_cfg_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (swr && lock) |=> $stable(fifo_thr));
endmodule

// File: tb/fdc_cfg_regs_tb.sv
module fdc_cfg_regs_tb;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dor_srst = 0, dsr_srst = 0, cfg_wr = 0, cfg_efifo = 0;
    logic [3:0] cfg_thr = 0;
    logic [7:0] cfg_trk = 0;
    logic perp_wr = 0, lock_wr = 0, dump_req = 0;
    logic [7:0] perp_cmd = 0, lock_cmd = 0;
    logic efifo, lock, wgate, gap, res_valid;
    logic [3:0] fifo_thr, drv_perp;
    logic [7:0] pretrk, res_byte;
    logic [1:0] perp_mode;
    logic [5:0] gap2_len, gap2_rewr;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit started = 0;

    always #(CLK_NS/2) clk = ~clk;

    fdc_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .dor_srst(dor_srst), .dsr_srst(dsr_srst),
        .cfg_wr(cfg_wr), .cfg_efifo(cfg_efifo), .cfg_thr(cfg_thr), .cfg_trk(cfg_trk),
        .perp_wr(perp_wr), .perp_cmd(perp_cmd), .lock_wr(lock_wr), .lock_cmd(lock_cmd),
        .dump_req(dump_req), .efifo(efifo), .fifo_thr(fifo_thr), .pretrk(pretrk),
        .lock(lock), .wgate(wgate), .gap(gap), .drv_perp(drv_perp),
        .perp_mode(perp_mode), .gap2_len(gap2_len), .gap2_rewr(gap2_rewr),
        .res_valid(res_valid), .res_byte(res_byte)
    );

    // Behavioural reference model
    int m_efifo, m_thr, m_trk, m_lock, m_wg, m_gap, m_drv, m_rv, m_rb;

    always @(posedge clk or negedge rst_n) begin
        int nv, nb;
        if (!rst_n) begin
            m_efifo = 1; m_thr = 0; m_trk = 0; m_lock = 0;
            m_wg = 0; m_gap = 0; m_drv = 0; m_rv = 0; m_rb = 0;
        end else begin
            nv = 0; nb = 0;
            if (dor_srst || dsr_srst) begin
                m_wg = 0; m_gap = 0;
                if (m_lock == 0) begin m_efifo = 1; m_thr = 0; m_trk = 0; end
            end else begin
                if (lock_wr) begin nv = 1; nb = lock_cmd[7] * 16; end
                else if (dump_req) begin
                    nv = 1;
                    nb = m_lock * 128 + m_drv * 4 + m_gap * 2 + m_wg;
                end
                if (cfg_wr) begin m_efifo = cfg_efifo; m_thr = cfg_thr; m_trk = cfg_trk; end
                if (perp_wr) begin
                    m_wg = perp_cmd[0]; m_gap = perp_cmd[1];
                    if (perp_cmd[7]) m_drv = perp_cmd[5:2];
                end
                if (lock_wr) m_lock = lock_cmd[7];
            end
            m_rv = nv; m_rb = nb;
        end
        started = 1;
    end

    function automatic int exp_mode(int wg, int gp);
        return (wg == 0 && gp == 0) ? 0 : (wg == 1 && gp == 0) ? 1 : (wg == 0) ? 2 : 3;
    endfunction
    function automatic int exp_len(int wg, int gp);
        return (wg == 1 && gp == 1) ? 41 : 22;
    endfunction
    function automatic int exp_rewr(int wg, int gp);
        return (wg == 1 && gp == 1) ? 38 : (wg == 1) ? 19 : 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "efifo", efifo, m_efifo);
            chk(cur_req, "fifo_thr", fifo_thr, m_thr);
            chk(cur_req, "pretrk", pretrk, m_trk);
            chk(cur_req, "lock", lock, m_lock);
            chk(cur_req, "wgate", wgate, m_wg);
            chk(cur_req, "gap", gap, m_gap);
            chk(cur_req, "drv_perp", drv_perp, m_drv);
            chk(cur_req, "res_valid", res_valid, m_rv);
            chk(cur_req, "res_byte", res_byte, m_rb);
            chk("R9", "perp_mode", perp_mode, exp_mode(m_wg, m_gap));
            chk("R9", "gap2_len", gap2_len, exp_len(m_wg, m_gap));
            chk("R9", "gap2_rewr", gap2_rewr, exp_rewr(m_wg, m_gap));
        end
    end

    task automatic step();
        @(negedge clk); #1;
        dor_srst = 0; dsr_srst = 0; cfg_wr = 0; perp_wr = 0; lock_wr = 0; dump_req = 0;
    endtask

    task automatic do_cfg(logic e, logic [3:0] t, logic [7:0] k);
        cfg_wr = 1; cfg_efifo = e; cfg_thr = t; cfg_trk = k; step();
    endtask
    task automatic do_perp(logic [7:0] b);
        perp_wr = 1; perp_cmd = b; step();
    endtask
    task automatic do_lock(logic [7:0] b);
        lock_wr = 1; lock_cmd = b; step();
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        // R1: reset values, checked against explicit constants
        chk("R1", "efifo", efifo, 1);
        chk("R1", "lock", lock, 0);
        chk("R1", "drv_perp", drv_perp, 0);
        chk("R1", "gap2_len", gap2_len, 22);
        chk("R1", "res_valid", res_valid, 0);
        rst_n = 1; step();

        cur_req = "R5"; do_cfg(0, 4'd5, 8'h22); step();
        chk("R5", "fifo_thr", fifo_thr, 5);

        cur_req = "R6"; do_perp(8'h97); step();      // drives 0101, gap 1, wgate 1
        chk("R9", "gap2_len p1m", gap2_len, 41);
        chk("R9", "gap2_rewr p1m", gap2_rewr, 38);
        do_perp(8'h01); step();                       // drive bits kept
        chk("R6", "drv_perp kept", drv_perp, 5);
        chk("R9", "gap2_rewr p500", gap2_rewr, 19);
        do_perp(8'h02); step();
        chk("R9", "perp_mode reserved", perp_mode, 2);
        chk("R9", "gap2_rewr reserved", gap2_rewr, 0);

        cur_req = "R8"; dump_req = 1; step();
        chk("R8", "dump byte", res_byte, 8'h16);
        step();

        cur_req = "R4"; dor_srst = 1; step(); step();
        chk("R4", "fifo_thr dflt", fifo_thr, 0);
        chk("R2", "drv_perp after swr", drv_perp, 5);

        cur_req = "R7"; do_cfg(0, 4'd9, 8'h40); do_perp(8'h03);
        do_lock(8'h80);
        chk("R7", "lock result", res_byte, 8'h10);
        step();

        cur_req = "R3"; dsr_srst = 1; step(); step();
        chk("R3", "fifo_thr held", fifo_thr, 9);
        chk("R3", "pretrk held", pretrk, 8'h40);
        chk("R2", "wgate cleared", wgate, 0);

        cur_req = "R8"; dump_req = 1; step();
        chk("R8", "dump byte locked", res_byte, 8'h94);
        step();

        cur_req = "R7"; do_lock(8'h7F);
        chk("R7", "unlock result", res_byte, 8'h00);
        chk("R7", "unlock valid", res_valid, 1);

        cur_req = "R10"; dsr_srst = 1; lock_wr = 1; lock_cmd = 8'h80;
        cfg_wr = 1; cfg_thr = 4'd3; step();
        chk("R10", "no result", res_valid, 0);
        chk("R10", "lock unchanged", lock, 0);
        step();

        cur_req = "R11"; lock_wr = 1; lock_cmd = 8'h80; dump_req = 1; step();
        chk("R11", "lock wins", res_byte, 8'h10);
        step();
        chk("R11", "valid one cycle", res_valid, 0);

        cur_req = "R1"; do_cfg(0, 4'd7, 8'h11); do_perp(8'hBF);
        rst_n = 0; step();
        chk("R1", "fifo_thr after hw", fifo_thr, 0);
        chk("R1", "lock after hw", lock, 0);
        chk("R1", "drv after hw", drv_perp, 0);
        rst_n = 1; step();

        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            dor_srst  = ($urandom % 11) == 0;
            dsr_srst  = ($urandom % 13) == 0;
            cfg_wr    = ($urandom % 4) == 0;
            cfg_efifo = $urandom;
            cfg_thr   = $urandom;
            cfg_trk   = $urandom;
            perp_wr   = ($urandom % 3) == 0;
            perp_cmd  = $urandom;
            lock_wr   = ($urandom % 5) == 0;
            lock_cmd  = $urandom;
            dump_req  = ($urandom % 4) == 0;
            step();
        end
        step(); step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule